// File: doc/BRIEF.md
# Log-Domain Fractional Hamming Matcher

This block decides whether a probe iris template matches a stored one. Both templates arrive together with their validity masks, one word of each per clock. Two counts build up while the words stream in. The first counts bit positions where the two templates differ and both masks mark the bit valid. The second counts bit positions that both masks mark valid. When the word flagged as last has been taken, the block forms the fraction of disagreeing valid bits without a divider. It takes an approximate base-2 logarithm of each count, subtracts the two logs, and converts the difference back with an approximate antilog.

Each logarithm finds the leading one of the count. Its position becomes the integer field, and the bits below it, shifted up to the top of the field, become the fraction. The antilog does the reverse: the fraction is placed behind an implied leading one, and the integer field sets how far the result is shifted. The fraction is compared with one third to give the match flag. A comparison with too few jointly valid bits is rejected whatever the fraction.

A new comparison starts with the first word after a last word, so comparisons can run back to back with no gap.

Top module: `hd_log_matcher`

## Requirements
- R1: The disagreement count covers only positions where the probe and stored bits differ and both masks are 1. Differences at positions where either mask is 0 have no effect on the result.
- R2: A comparison whose joint-valid count is below TOTAL_BITS/2+1 (8281 at the default 16560 bits) gives is_reject=1, is_match=0 and ratio=0. With 8280 valid bits it is rejected, and with 8281 it is not.
- R3: The log of a count N has an integer part equal to the bit index of the leading one of N. Its FRAC_W-bit fraction is the bits below that leading one, left aligned. Powers of two and equal counts are therefore exact: 16384/16384 gives ratio 1024, 4096/16384 gives 256, and 8192/16384 gives 512.
- R4: The difference D = log(den) - log(num) splits into an integer part I and a fraction F. The ratio is ((2<<FRAC_W) - F) >> (I+1), unsigned, with 1 integer bit and FRAC_W fraction bits, so 1.0 is 1024 at the default. Examples: 12288/16384 gives 768, 8192/12288 gives 768, 2048/12288 gives 192, and 5000/15000 gives 355.
- R5: A disagreement count of zero with enough valid bits gives ratio=0 and is_match=1.
- R6: When a result is not rejected, is_match=1 exactly when ratio < (THR_NUM<<FRAC_W)/THR_DEN, which is 341 at the default threshold of one third.
- R7: res_valid is high for one cycle, after the third rising edge counted from the edge that takes the last word. ratio, is_match and is_reject keep their values until the next res_valid.
- R8: For any count pair that is not rejected, |ratio - 1024*num/den| <= 0.15*(1024*num/den) + 2.
- R9: The counts restart with the first word after a last word, so a comparison is not affected by the one before it.
- R10: After reset, res_valid, ratio, is_match and is_reject are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | A template word is present this cycle |
| word_last | input | 1 | This word closes the comparison |
| probe_bits | input | WORD_W | Probe template word |
| probe_mask | input | WORD_W | Probe validity mask word (1 = valid) |
| ref_bits | input | WORD_W | Stored template word |
| ref_mask | input | WORD_W | Stored validity mask word (1 = valid) |
| res_valid | output | 1 | One-cycle pulse: a new result is on the outputs |
| ratio | output | FRAC_W+1 | Approximate fraction of disagreeing valid bits, 1.FRAC_W unsigned |
| is_match | output | 1 | Ratio is below the threshold and the comparison is not rejected |
| is_reject | output | 1 | Too few jointly valid bits |

## Verification
The stream always puts disagreements in positions that only one mask marks valid, so any leak from masked bits shows up in the ratio. Count pairs at exact powers of two and equal counts give a single correct answer, and they separate a faulty leading-one index or fraction alignment from ordinary approximation error. Off-power pairs with values worked out by hand (768, 192, 355) exercise the subtract and antilog shift. Random pairs are held to the approximation error bound and to the consistency between the threshold and the flag. Joint-valid counts of 8280 and 8281 mark the reject edge, and zero-count comparisons placed right after large ones expose any count carried over from the previous comparison.

// File: rtl/hd_match_pkg.sv
package hd_match_pkg;
  localparam int unsigned DEF_WORD_W     = 32;
  localparam int unsigned DEF_TOTAL_BITS = 16560;
  localparam int unsigned DEF_FRAC_W     = 10;

  typedef struct packed {
    logic num_zero;
    logic too_few;
  } hd_flags_t;

  function automatic int unsigned min_valid_bits(input int unsigned total);
    return total / 2 + 1;
  endfunction
endpackage

// File: rtl/hd_popcount_acc.sv
module hd_popcount_acc #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned CNT_W  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              restart,
  input  logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  count
);
  localparam int unsigned POP_W = $clog2(WORD_W + 1);

  logic [POP_W-1:0] pop;

  always_comb begin
    pop = '0;
    for (int i = 0; i < int'(WORD_W); i++) begin
      pop = pop + POP_W'(word[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (in_valid) begin
      count <= (restart ? '0 : count) + CNT_W'(pop);
    end
  end
endmodule

// File: rtl/hd_lead_one.sv
module hd_lead_one #(
  parameter int unsigned IN_W  = 15,
  parameter int unsigned IDX_W = 4
) (
  input  logic [IN_W-1:0]  value,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < int'(IN_W); i++) begin
      if (value[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/hd_log2_approx.sv
module hd_log2_approx #(
  parameter int unsigned IN_W   = 15,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned FRAC_W = 10
) (
  input  logic [IN_W-1:0]   value,
  output logic [IDX_W-1:0]  log_int,
  output logic [FRAC_W-1:0] log_frac
);
  localparam int unsigned EXT_W = IN_W - 1 + FRAC_W;

  logic [IDX_W-1:0] lead;
  logic [IDX_W-1:0] sh;
  logic [IN_W-1:0]  norm;
  logic [EXT_W-1:0] ext;

  hd_lead_one #(.IN_W(IN_W), .IDX_W(IDX_W)) u_lead (
    .value(value),
    .idx  (lead)
  );

  always_comb begin
    sh       = IDX_W'(IN_W - 1) - lead;
    norm     = value << sh;
    ext      = {norm[IN_W-2:0], {FRAC_W{1'b0}}};
    log_int  = lead;
    log_frac = ext[EXT_W-1 -: FRAC_W];
  end
endmodule

// File: rtl/hd_antilog_approx.sv
module hd_antilog_approx #(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned FRAC_W = 10
) (
  input  logic [IDX_W-1:0]  neg_int,
  input  logic [FRAC_W-1:0] neg_frac,
  output logic [FRAC_W:0]   ratio
);
  logic [FRAC_W+1:0] base;
  logic [FRAC_W+1:0] shifted;
  logic [IDX_W:0]    sh;

  always_comb begin
    base    = {2'b10, {FRAC_W{1'b0}}} - {2'b00, neg_frac};
    sh      = {1'b0, neg_int} + (IDX_W + 1)'(1);
    shifted = base >> sh;
    ratio   = shifted[FRAC_W:0];
  end
endmodule

// File: rtl/hd_log_matcher.sv
module hd_log_matcher
  import hd_match_pkg::*;
#(
  parameter int unsigned WORD_W     = DEF_WORD_W,
  parameter int unsigned TOTAL_BITS = DEF_TOTAL_BITS,
  parameter int unsigned FRAC_W     = DEF_FRAC_W,
  parameter int unsigned THR_NUM    = 1,
  parameter int unsigned THR_DEN    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_valid,
  input  logic              word_last,
  input  logic [WORD_W-1:0] probe_bits,
  input  logic [WORD_W-1:0] probe_mask,
  input  logic [WORD_W-1:0] ref_bits,
  input  logic [WORD_W-1:0] ref_mask,
  output logic              res_valid,
  output logic [FRAC_W:0]   ratio,
  output logic              is_match,
  output logic              is_reject
);
  localparam int unsigned CNT_W     = $clog2(TOTAL_BITS + 1);
  localparam int unsigned IDX_W     = $clog2(CNT_W);
  localparam int unsigned LOG_W     = IDX_W + FRAC_W;
  localparam int unsigned MIN_VALID = min_valid_bits(TOTAL_BITS);
  localparam int unsigned ONE_Q     = 1 << FRAC_W;
  localparam int unsigned THR_Q     = THR_NUM * ONE_Q / THR_DEN;
  localparam logic [FRAC_W:0] THR_V = (FRAC_W + 1)'(THR_Q);

  // index 0: disagreeing valid bits, index 1: jointly valid bits
  logic [WORD_W-1:0] acc_word [2];
  logic [CNT_W-1:0]  cnt      [2];
  logic [LOG_W-1:0]  log_c    [2];
  logic [LOG_W-1:0]  log_q    [2];
  logic              fresh;
  logic              s1_go, s2_go;
  hd_flags_t         flags_q;

  always_comb begin
    acc_word[0] = (probe_bits ^ ref_bits) & probe_mask & ref_mask;
    acc_word[1] = probe_mask & ref_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fresh <= 1'b1;
      s1_go <= 1'b0;
    end else begin
      s1_go <= word_valid && word_last;
      if (word_valid) fresh <= word_last;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_path
    logic [IDX_W-1:0]  li;
    logic [FRAC_W-1:0] lf;

    hd_popcount_acc #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_acc (
      .clk     (clk),
      .rst     (rst),
      .in_valid(word_valid),
      .restart (fresh),
      .word    (acc_word[g]),
      .count   (cnt[g])
    );

    hd_log2_approx #(.IN_W(CNT_W), .IDX_W(IDX_W), .FRAC_W(FRAC_W)) u_log (
      .value   (cnt[g]),
      .log_int (li),
      .log_frac(lf)
    );

    assign log_c[g] = {li, lf};

    always_ff @(posedge clk) begin
      if (rst) log_q[g] <= '0;
      else if (s1_go) log_q[g] <= log_c[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      s2_go   <= 1'b0;
    end else begin
      s2_go <= s1_go;
      if (s1_go) begin
        flags_q.num_zero <= (cnt[0] == '0);
        flags_q.too_few  <= (cnt[1] < CNT_W'(MIN_VALID));
      end
    end
  end

  logic [LOG_W-1:0] neg;
  logic [FRAC_W:0]  al_ratio;

  assign neg = log_q[1] - log_q[0];

  hd_antilog_approx #(.IDX_W(IDX_W), .FRAC_W(FRAC_W)) u_alog (
    .neg_int (neg[LOG_W-1:FRAC_W]),
    .neg_frac(neg[FRAC_W-1:0]),
    .ratio   (al_ratio)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      ratio     <= '0;
      is_match  <= 1'b0;
      is_reject <= 1'b0;
    end else begin
      res_valid <= s2_go;
      if (s2_go) begin
        if (flags_q.too_few) begin
          ratio     <= '0;
          is_match  <= 1'b0;
          is_reject <= 1'b1;
        end else if (flags_q.num_zero) begin
          ratio     <= '0;
          is_match  <= 1'b1;
          is_reject <= 1'b0;
        end else begin
          ratio     <= al_ratio;
          is_match  <= (al_ratio < THR_V);
          is_reject <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/hd_log_matcher_chk.sv
module hd_log_matcher_chk #(
  parameter int unsigned FRAC_W = 10,
  parameter int unsigned THR_Q  = 341
) (
  input logic            clk,
  input logic            rst,
  input logic            word_valid,
  input logic            word_last,
  input logic            res_valid,
  input logic [FRAC_W:0] ratio,
  input logic            is_match,
  input logic            is_reject
);
  localparam logic [FRAC_W:0] ONE_V = (FRAC_W + 1)'(1) << FRAC_W;
  localparam logic [FRAC_W:0] THR_V = (FRAC_W + 1)'(THR_Q);

  a_r2_reject_clears: assert property (@(posedge clk) disable iff (rst)
    is_reject |-> (!is_match && ratio == '0));

  a_r4_ratio_le_one: assert property (@(posedge clk) disable iff (rst)
    ratio <= ONE_V);

  a_r6_match_below_thr: assert property (@(posedge clk) disable iff (rst)
    is_match |-> ratio < THR_V);

  a_r7_latency: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(word_valid && word_last, 3));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> ($stable(ratio) && $stable(is_match) && $stable(is_reject)));
endmodule

bind hd_log_matcher hd_log_matcher_chk #(.FRAC_W(FRAC_W), .THR_Q(THR_Q)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .word_valid(word_valid),
  .word_last (word_last),
  .res_valid (res_valid),
  .ratio     (ratio),
  .is_match  (is_match),
  .is_reject (is_reject)
);

// File: tb/hd_log_matcher_test.sv
module hd_log_matcher_test;
  localparam int W   = 32;
  localparam int FW  = 10;
  localparam int THR = 341;
  localparam int NV  = 12;
  // n, d, expected ratio (-1: bound only), expected match, expected reject
  localparam int VEC [NV][5] = '{
    '{0,     16560, 0,    1, 0},
    '{16384, 16384, 1024, 0, 0},
    '{4096,  16384, 256,  1, 0},
    '{12288, 16384, 768,  0, 0},
    '{8192,  12288, 768,  0, 0},
    '{2048,  12288, 192,  1, 0},
    '{0,     8280,  0,    0, 1},
    '{100,   8281,  -1,   1, 0},
    '{5000,  8000,  0,    0, 1},
    '{0,     0,     0,    0, 1},
    '{8192,  16384, 512,  0, 0},
    '{5000,  15000, 355,  0, 0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic word_valid = 1'b0, word_last = 1'b0;
  logic [W-1:0] probe_bits = '0, probe_mask = '0, ref_bits = '0, ref_mask = '0;
  logic res_valid, is_match, is_reject;
  logic [FW:0] ratio;
  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hd_log_matcher uut (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_last(word_last),
    .probe_bits(probe_bits), .probe_mask(probe_mask),
    .ref_bits(ref_bits), .ref_mask(ref_mask),
    .res_valid(res_valid), .ratio(ratio), .is_match(is_match), .is_reject(is_reject)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Streams a comparison with n disagreeing valid bits and d jointly valid bits.
  // Extra disagreements sit where only the probe mask is set (R1).
  task automatic run_case(input int n, input int d, output int lat);
    int nw;
    nw = d / W + 1;
    for (int w = 0; w < nw; w++) begin
      @(negedge clk);
      word_valid = 1'b1;
      word_last  = (w == nw - 1);
      for (int b = 0; b < W; b++) begin
        int k;
        k = w * W + b;
        probe_mask[b] = 1'b1;
        ref_mask[b]   = (k < d);
        probe_bits[b] = k[0] ^ k[3];
        ref_bits[b]   = probe_bits[b] ^ ((k < n) || (k >= d));
      end
    end
    @(negedge clk);
    word_valid = 1'b0;
    word_last  = 1'b0;
    lat = 1;
    while (!res_valid && lat < 10) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int lat, r;
    repeat (3) @(negedge clk);
    check(res_valid == 0 && ratio == 0 && is_match == 0 && is_reject == 0,
          "R10 reset outputs", int'(ratio), 0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      run_case(VEC[v][0], VEC[v][1], lat);
      check(lat == 3, "R7 latency", lat, 3);
      r = int'(ratio);
      if (VEC[v][2] >= 0)
        check(r == VEC[v][2], "R1 R3 R4 R5 R9 ratio", r, VEC[v][2]);
      check(int'(is_match) == VEC[v][3], "R5 R6 match", int'(is_match), VEC[v][3]);
      check(int'(is_reject) == VEC[v][4], "R2 reject", int'(is_reject), VEC[v][4]);
    end

    // R8 and R6 on random count pairs
    for (int t = 0; t < 16; t++) begin
      int n, d;
      real ex, tol, diff;
      d = int'($urandom_range(16560, 8281));
      n = int'($urandom_range(d, 1));
      run_case(n, d, lat);
      r = int'(ratio);
      ex = real'(n) * 1024.0 / real'(d);
      tol = 0.15 * ex + 2.0;
      diff = real'(r) - ex;
      if (diff < 0.0) diff = -diff;
      check(diff <= tol, "R8 error bound", r, int'(ex));
      check(is_match == (r < THR), "R6 threshold", int'(is_match), int'(r < THR));
      check(is_reject == 0, "R2 accepted", int'(is_reject), 0);
    end

    // R9: a large ratio followed directly by a zero-disagreement comparison
    run_case(16560, 16560, lat);
    check(int'(ratio) == 1024, "R9 first", int'(ratio), 1024);
    run_case(0, 9000, lat);
    check(ratio == 0 && is_match == 1, "R9 restart", int'(ratio), 0);

    // R7: outputs hold, no pulse while idle
    run_case(4096, 16384, lat);
    @(negedge clk);
    check(res_valid == 0, "R7 single pulse", int'(res_valid), 0);
    repeat (6) @(negedge clk);
    check(int'(ratio) == 256 && is_match == 1, "R7 hold", int'(ratio), 256);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule